// File: doc/BRIEF.md
# Row Steering Sequencer with Token Cascade

This block drives the per-row select (gate) and clear lines of a pixel matrix that is read out one row at a time. For every row it replays a short programmable step list. A typical list samples the charged cells, pulses clear on that same row, samples the emptied cells, and then hands over to the next row. Only one row is ever driven, and rows are visited in ascending order. A one-cycle strobe tells the readout when to take each sample.

One instance drives 64 rows. To cover a taller matrix, instances are chained: the done pulse of one feeds the token input of the next. The host loads the step list while the block is idle, then starts a frame with a start pulse. Downstream instances start on the token instead.

The controller has four states, with these transitions:
- IDLE: goes to SETUP on start or token.
- SETUP: fetches the current step.
  - A zero duration ends the row. This goes to SETUP of the next row, or to DONE after the last row.
  - Otherwise it goes to RUN.
- RUN: drives the step's phase while the duration counts down.
  - When the count expires, it goes to SETUP of the next step.
  - After the last table step, the row ends and it goes to SETUP of the next row, or to DONE.
- DONE: goes to IDLE.

Top module: `row_steer_seq`

## Requirements
- R1: A low `rst_n` at a clock edge (synchronous) deasserts every gate and clear line, `sample`, `busy` and `token_out`, and zeroes every step-table entry.
- R2: A write with `cfg_we` high in IDLE stores the phase code and duration at step `cfg_addr`. The phase codes are: 0 idle, 1 select-filled, 2 clear, 3 select-empty.
- R3: Steps are executed from index 0 upward. Each step costs one SETUP cycle with all lines low, then `duration` cycles of its phase. A step with duration 0 ends the row after its SETUP cycle. The row also ends after the last table step. A step with phase idle drives no line.
- R4: Rows 0 to 63 are driven in ascending order, and at most one row line (gate or clear) is high in any cycle.
- R5: Gate and clear are never high on the same row in the same cycle. Per row, gate is high for the sum of the select-step durations, and clear is high for the sum of the clear-step durations, in table order.
- R6: `sample` is high for exactly one cycle, the last cycle of every select step, together with that row's gate.
- R7: `start` or `token_in` in IDLE begins a frame. `busy` is high from the next cycle, for 64 × (row length) cycles.
- R8: After the final step of row 63, `token_out` is high for exactly one cycle with `busy` low, and then the block is idle.
- R9: While `busy` is high, `start`, `token_in` and `cfg_we` have no effect.
- R10: With one instance's `token_out` driving the next one's `token_in`, the second runs its full frame starting the cycle after the pulse, and the two are never busy together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous reset, active low |
| start | input | 1 | host frame start |
| token_in | input | 1 | frame start from upstream instance |
| cfg_we | input | 1 | step-table write enable |
| cfg_addr | input | 3 | step index to write |
| cfg_phase | input | 2 | phase code to write |
| cfg_dur | input | 8 | duration in cycles to write |
| gate | output | 64 | per-row select lines |
| clear | output | 64 | per-row clear lines |
| sample | output | 1 | readout sample strobe |
| busy | output | 1 | frame in progress |
| token_out | output | 1 | frame complete, one-cycle pulse |

## Verification
The bench targets four corner cases:
- A table whose first entry has zero duration. A design that ignored the terminator would run stale steps, and the busy count would show it.
- A full table with no terminator. A design that kept wrapping would never reach the last row.
- Writes, starts and tokens arriving mid-frame. A design that accepted them would stretch the frame or corrupt the next one.
- A reset during a frame. A design that kept the table or left a row line high would fail the post-reset frame length.

Per-row gate and clear totals, the gate count before the first clear, and sample placement expose mis-ordered or overlapping phases. The chained pair checks that the token hand-off starts the second frame exactly one cycle later.

// File: rtl/row_steer_pkg.sv
`timescale 1ns/1ps
package row_steer_pkg;
    typedef enum logic [1:0] {
        PH_IDLE      = 2'd0,
        PH_SEL_FULL  = 2'd1,
        PH_CLEAR     = 2'd2,
        PH_SEL_EMPTY = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SETUP = 2'd1,
        S_RUN   = 2'd2,
        S_DONE  = 2'd3
    } state_t;
endpackage

// File: rtl/row_steer_pattern.sv
`timescale 1ns/1ps
module row_steer_pattern
    import row_steer_pkg::*;
#(
    parameter int N_STEPS = 8,
    parameter int DUR_W   = 8,
    localparam int STEP_W = $clog2(N_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [STEP_W-1:0] wr_addr,
    input  phase_t            wr_phase,
    input  logic [DUR_W-1:0]  wr_dur,
    input  logic [STEP_W-1:0] rd_addr,
    output phase_t            rd_phase,
    output logic [DUR_W-1:0]  rd_dur
);
    phase_t           ph_q  [N_STEPS];
    logic [DUR_W-1:0] dur_q [N_STEPS];

    for (genvar i = 0; i < N_STEPS; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ph_q[i]  <= PH_IDLE;
                dur_q[i] <= '0;
            end else if (wr_en && wr_addr == STEP_W'(i)) begin
                ph_q[i]  <= wr_phase;
                dur_q[i] <= wr_dur;
            end
        end
    end

    assign rd_phase = ph_q[rd_addr];
    assign rd_dur   = dur_q[rd_addr];
endmodule

// File: rtl/row_steer_rowdec.sv
`timescale 1ns/1ps
module row_steer_rowdec #(
    parameter int N_ROWS = 64,
    localparam int ROW_W = $clog2(N_ROWS)
) (
    input  logic [ROW_W-1:0]  row,
    input  logic              gate_on,
    input  logic              clear_on,
    output logic [N_ROWS-1:0] gate,
    output logic [N_ROWS-1:0] clear
);
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        assign gate[r]  = gate_on  && (row == ROW_W'(r));
        assign clear[r] = clear_on && (row == ROW_W'(r));
    end
endmodule

// File: rtl/row_steer_seq.sv
`timescale 1ns/1ps
module row_steer_seq
    import row_steer_pkg::*;
#(
    parameter int N_ROWS  = 64,
    parameter int N_STEPS = 8,
    parameter int DUR_W   = 8,
    localparam int ROW_W  = $clog2(N_ROWS),
    localparam int STEP_W = $clog2(N_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              token_in,
    input  logic              cfg_we,
    input  logic [STEP_W-1:0] cfg_addr,
    input  logic [1:0]        cfg_phase,
    input  logic [DUR_W-1:0]  cfg_dur,
    output logic [N_ROWS-1:0] gate,
    output logic [N_ROWS-1:0] clear,
    output logic              sample,
    output logic              busy,
    output logic              token_out
);
    localparam logic [ROW_W-1:0]  LAST_ROW  = ROW_W'(N_ROWS - 1);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(N_STEPS - 1);

    state_t            state_q, state_nx;
    logic [ROW_W-1:0]  row_q, row_nx;
    logic [STEP_W-1:0] step_q, step_nx;
    logic [DUR_W-1:0]  cnt_q, cnt_nx;
    phase_t            ph_q, ph_nx;
    phase_t            tbl_phase;
    logic [DUR_W-1:0]  tbl_dur;
    logic              row_end;
    logic              gate_on, clear_on;

    row_steer_pattern #(.N_STEPS(N_STEPS), .DUR_W(DUR_W)) u_pattern (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we && state_q == S_IDLE),
        .wr_addr  (cfg_addr),
        .wr_phase (phase_t'(cfg_phase)),
        .wr_dur   (cfg_dur),
        .rd_addr  (step_q),
        .rd_phase (tbl_phase),
        .rd_dur   (tbl_dur)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        row_nx   = row_q;
        step_nx  = step_q;
        cnt_nx   = cnt_q;
        ph_nx    = ph_q;
        row_end  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start || token_in) begin
                    state_nx = S_SETUP;
                    row_nx   = '0;
                    step_nx  = '0;
                end
            end
            S_SETUP: begin
                if (tbl_dur == '0) begin
                    row_end = 1'b1;
                end else begin
                    cnt_nx   = tbl_dur - DUR_W'(1);
                    ph_nx    = tbl_phase;
                    state_nx = S_RUN;
                end
            end
            S_RUN: begin
                if (cnt_q != '0) begin
                    cnt_nx = cnt_q - DUR_W'(1);
                end else if (step_q == LAST_STEP) begin
                    row_end = 1'b1;
                end else begin
                    step_nx  = step_q + STEP_W'(1);
                    state_nx = S_SETUP;
                end
            end
            S_DONE: state_nx = S_IDLE;
        endcase
        if (row_end) begin
            if (row_q == LAST_ROW) begin
                state_nx = S_DONE;
            end else begin
                row_nx   = row_q + ROW_W'(1);
                step_nx  = '0;
                state_nx = S_SETUP;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            row_q   <= '0;
            step_q  <= '0;
            cnt_q   <= '0;
            ph_q    <= PH_IDLE;
        end else begin
            state_q <= state_nx;
            row_q   <= row_nx;
            step_q  <= step_nx;
            cnt_q   <= cnt_nx;
            ph_q    <= ph_nx;
        end
    end

    // outputs
    always_comb begin
        gate_on   = (state_q == S_RUN) && (ph_q == PH_SEL_FULL || ph_q == PH_SEL_EMPTY);
        clear_on  = (state_q == S_RUN) && (ph_q == PH_CLEAR);
        sample    = gate_on && (cnt_q == '0);
        busy      = (state_q == S_SETUP) || (state_q == S_RUN);
        token_out = (state_q == S_DONE);
    end

    row_steer_rowdec #(.N_ROWS(N_ROWS)) u_rowdec (
        .row      (row_q),
        .gate_on  (gate_on),
        .clear_on (clear_on),
        .gate     (gate),
        .clear    (clear)
    );
endmodule

// File: rtl/row_steer_chk.sv
`timescale 1ns/1ps
module row_steer_chk #(
    parameter int N_ROWS = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              token_in,
    input logic [N_ROWS-1:0] gate,
    input logic [N_ROWS-1:0] clear,
    input logic              sample,
    input logic              busy,
    input logic              token_out
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (gate == '0 && clear == '0 && !sample && !busy && !token_out));

    p_one_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate | clear));

    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate & clear) == '0);

    p_sample_with_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> (gate != '0));

    p_sample_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample |=> (gate == '0));

    p_lines_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate | clear) != '0) |-> busy);

    p_launch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !token_out && (start || token_in)) |=> busy);

    p_token_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |=> !token_out);

    p_token_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        token_out |-> !busy);
endmodule

bind row_steer_seq row_steer_chk #(.N_ROWS(N_ROWS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .token_in  (token_in),
    .gate      (gate),
    .clear     (clear),
    .sample    (sample),
    .busy      (busy),
    .token_out (token_out)
);

// File: tb/row_steer_seq_bench.sv
`timescale 1ns/1ps
module row_steer_seq_bench;
    localparam int NR = 64;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, tok_in = 1'b0, chain_en = 1'b0;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [1:0]    cfg_phase = '0;
    logic [7:0]    cfg_dur = '0;
    logic [NR-1:0] gate_a, clear_a, gate_b, clear_b;
    logic          samp_a, busy_a, tok_a, samp_b, busy_b, tok_b;

    always #5 clk = ~clk;

    row_steer_seq u_row_steer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .token_in(tok_in),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_phase(cfg_phase), .cfg_dur(cfg_dur),
        .gate(gate_a), .clear(clear_a), .sample(samp_a), .busy(busy_a), .token_out(tok_a));

    row_steer_seq u_row_steer_seq_b (
        .clk(clk), .rst_n(rst_n), .start(1'b0), .token_in(tok_a && chain_en),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_phase(cfg_phase), .cfg_dur(cfg_dur),
        .gate(gate_b), .clear(clear_b), .sample(samp_b), .busy(busy_b), .token_out(tok_b));

    int total = 0, bad = 0;
    int ph [NS];
    int du [NS];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor state for instance a
    bit mon = 0;
    int busy_cnt, samp_cnt, tok_cnt, last_row;
    bit e_overlap, e_multi, e_order, e_samp, e_tokbusy, prev_samp;
    int gcnt [NR];
    int ccnt [NR];
    int pre  [NR];
    bit seen [NR];
    // monitor for instance b
    int busy_b_cnt, tok_b_cnt;
    bit e_both, e_handoff, prev_tok_a;

    task automatic mon_clear();
        busy_cnt = 0; samp_cnt = 0; tok_cnt = 0; last_row = 0;
        e_overlap = 0; e_multi = 0; e_order = 0; e_samp = 0; e_tokbusy = 0; prev_samp = 0;
        busy_b_cnt = 0; tok_b_cnt = 0; e_both = 0; e_handoff = 0; prev_tok_a = 0;
        for (int r = 0; r < NR; r++) begin
            gcnt[r] = 0; ccnt[r] = 0; pre[r] = -1; seen[r] = 0;
        end
    endtask

    always @(negedge clk) begin
        if (mon) begin
            if (busy_a) busy_cnt++;
            if (busy_b) busy_b_cnt++;
            if (busy_a && busy_b) e_both = 1;
            if (prev_tok_a && chain_en && !busy_b) e_handoff = 1;
            prev_tok_a = tok_a;
            if ((gate_a & clear_a) != '0) e_overlap = 1;
            if ($countones(gate_a | clear_a) > 1) e_multi = 1;
            for (int r = 0; r < NR; r++) begin
                if (gate_a[r] || clear_a[r]) begin
                    if (r < last_row) e_order = 1;
                    last_row = r;
                end
                if (clear_a[r] && !seen[r]) begin
                    seen[r] = 1;
                    pre[r] = gcnt[r];
                end
                if (gate_a[r]) gcnt[r]++;
                if (clear_a[r]) ccnt[r]++;
            end
            if (prev_samp && gate_a != '0) e_samp = 1;
            if (samp_a) begin
                samp_cnt++;
                if (gate_a == '0) e_samp = 1;
            end
            prev_samp = samp_a;
            if (tok_a) begin
                tok_cnt++;
                if (busy_a) e_tokbusy = 1;
            end
            if (tok_b) tok_b_cnt++;
        end
    end

    task automatic program_table();
        for (int k = 0; k < NS; k++) begin
            @(negedge clk);
            cfg_we = 1; cfg_addr = 3'(k); cfg_phase = 2'(ph[k]); cfg_dur = 8'(du[k]);
        end
        @(negedge clk);
        cfg_we = 0;
    endtask

    // launch a frame (via start or token), optionally disturb it, then check it
    task automatic run_frame(input bit use_tok, input bit disturb, input bit chain);
        int kk, plen, gsum, csum, nsel, pexp;
        bit has_clr, all_g, all_c, all_p;
        int wd;
        kk = NS;
        for (int k = NS - 1; k >= 0; k--) if (du[k] == 0) kk = k;
        plen = (kk < NS) ? 1 : 0;
        gsum = 0; csum = 0; nsel = 0; pexp = 0; has_clr = 0;
        for (int k = 0; k < kk; k++) begin
            plen += 1 + du[k];
            if (ph[k] == 1 || ph[k] == 3) begin
                gsum += du[k]; nsel++;
                if (!has_clr) pexp += du[k];
            end
            if (ph[k] == 2) begin
                csum += du[k]; has_clr = 1;
            end
        end
        chain_en = chain;
        mon_clear();
        mon = 1;
        @(negedge clk);
        if (use_tok) tok_in = 1; else start = 1;
        @(negedge clk);
        tok_in = 0; start = 0;
        if (disturb) begin
            repeat (20) @(negedge clk);
            // R9: mid-frame write, start and token must be ignored
            cfg_we = 1; cfg_addr = 3'd0; cfg_phase = 2'd2; cfg_dur = 8'd9;
            start = 1; tok_in = 1;
            @(negedge clk);
            cfg_we = 0; start = 0; tok_in = 0;
        end
        wd = 0;
        while (!(chain ? tok_b_cnt > 0 : tok_cnt > 0) && wd < 40000) begin
            @(negedge clk);
            wd++;
        end
        repeat (3) @(negedge clk);
        mon = 0;
        check(wd < 40000, "R8 frame completes", wd, 0);
        check(busy_cnt == NR * plen, "R3/R7 busy length", busy_cnt, NR * plen);
        check(tok_cnt == 1, "R8 single token pulse", tok_cnt, 1);
        check(!e_tokbusy, "R8 token with busy low", e_tokbusy, 0);
        check(!e_multi, "R4 one row line at a time", e_multi, 0);
        check(!e_order, "R4 ascending rows", e_order, 0);
        check(!e_overlap, "R5 no gate/clear overlap", e_overlap, 0);
        all_g = 1; all_c = 1; all_p = 1;
        for (int r = 0; r < NR; r++) begin
            if (gcnt[r] != gsum) all_g = 0;
            if (ccnt[r] != csum) all_c = 0;
            if (has_clr && pre[r] != pexp) all_p = 0;
        end
        check(all_g, "R5 gate cycles per row", gcnt[NR-1], gsum);
        check(all_c, "R5 clear cycles per row", ccnt[NR-1], csum);
        check(all_p, "R5 select before clear", pre[0], pexp);
        check(samp_cnt == NR * nsel, "R6 sample count", samp_cnt, NR * nsel);
        check(!e_samp, "R6 sample on last gate cycle", e_samp, 0);
        if (chain) begin
            check(busy_b_cnt == NR * plen, "R10 chained frame length", busy_b_cnt, NR * plen);
            check(!e_handoff, "R10 hand-off next cycle", e_handoff, 0);
            check(!e_both, "R10 never busy together", e_both, 0);
            check(tok_b_cnt == 1, "R10 chained token", tok_b_cnt, 1);
        end
    endtask

    task automatic set_step(input int k, input int p, input int d);
        ph[k] = p; du[k] = d;
    endtask

    initial begin
        #1_500_000;
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(gate_a == '0 && clear_a == '0 && !samp_a && !busy_a && !tok_a,
              "R1 reset outputs", int'(busy_a), 0);
        rst_n = 1;

        // R2/R3: fill-clear-empty with terminator
        for (int k = 0; k < NS; k++) set_step(k, 0, 0);
        set_step(0, 1, 3); set_step(1, 2, 2); set_step(2, 3, 3);
        program_table();
        run_frame(0, 0, 0);

        // R3: full table, idle steps, no terminator; started by token (R7)
        set_step(0, 1, 1); set_step(1, 2, 1); set_step(2, 3, 1); set_step(3, 0, 2);
        set_step(4, 1, 2); set_step(5, 2, 1); set_step(6, 3, 2); set_step(7, 0, 1);
        program_table();
        run_frame(1, 0, 0);

        // R3: terminator at step 0 masks later entries
        set_step(0, 1, 0);
        program_table();
        run_frame(0, 0, 0);

        // R9: disturbance mid-frame, then rerun unchanged table
        for (int k = 0; k < NS; k++) set_step(k, 0, 0);
        set_step(0, 1, 20); set_step(1, 2, 5); set_step(2, 3, 20);
        program_table();
        run_frame(0, 1, 0);
        run_frame(0, 0, 0);

        // R10: chained pair
        set_step(0, 3, 2); set_step(1, 2, 1); set_step(2, 1, 2);
        program_table();
        run_frame(0, 0, 1);

        // R1: reset mid-frame clears lines and the table
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (30) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check(gate_a == '0 && clear_a == '0 && !samp_a && !busy_a && !tok_a,
              "R1 mid-frame reset", int'(busy_a), 0);
        rst_n = 1;
        for (int k = 0; k < NS; k++) set_step(k, 0, 0);
        run_frame(0, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule